// File: doc/BRIEF.md
# Mode-Selected ALU with Registered Status Flags

This block is a parameterised arithmetic/logic unit for a processor datapath. One operand path runs through a single parallel adder. A mode input chooses between arithmetic and logic work. In arithmetic mode, a two-bit function select sets the value that feeds the adder's second input: the operand, its complement, all zeros or all ones. The carry input then picks between the two operations of each pair. This covers add, add-with-carry, ones'-complement add, subtract, transfer, increment and decrement. In logic mode the same select bits choose a bitwise operation, and the carry input has no effect.

The result leaves the block combinationally. Four condition flags are computed from each operation: zero, signed overflow, carry and sign. They are captured into a status register on a clock edge when a load strobe is high. The surrounding control logic raises that strobe only for instructions that should update the condition codes. A synchronous reset clears the register.

Top module: `alu_mode_flags`

## Requirements
- R1: With `mode_logic` = 1, `fsel` selects the result: 00 gives A AND B, 01 gives A OR B, 10 gives A XOR B, and 11 gives NOT A.
- R2: With `mode_logic` = 0 and `fsel` = 00, the result is A + B + cin, modulo 2^WIDTH.
- R3: With `mode_logic` = 0 and `fsel` = 01, the result is A + NOT B + cin. With cin = 1 this is A minus B.
- R4: With `mode_logic` = 0 and `fsel` = 10, the result is A + cin. This transfers A when cin = 0 and increments A when cin = 1.
- R5: With `mode_logic` = 0 and `fsel` = 11, the result is A + all-ones + cin. This decrements A when cin = 0 and transfers A when cin = 1.
- R6: In logic mode, `cin` has no effect on the result or on any flag.
- R7: In arithmetic mode, the carry flag is the carry out of the adder's most significant bit. The overflow flag is set when both adder inputs share a sign bit and the result's sign bit differs from it.
- R8: The zero flag is set exactly when the result is all zeros. The sign flag equals the result's most significant bit.
- R9: In logic mode, the carry and overflow flags are cleared.
- R10: On a rising clock edge with `flag_ld` = 1, all four flag outputs take the values computed from that cycle's inputs. With `flag_ld` = 0, they keep their previous values.
- R11: A rising clock edge with `rst` = 1 clears all four flag outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high, clears the flags |
| opd_a | input | WIDTH | Operand A |
| opd_b | input | WIDTH | Operand B |
| mode_logic | input | 1 | 0 selects arithmetic mode, 1 selects logic mode |
| fsel | input | 2 | Function select within the mode |
| cin | input | 1 | Carry input to the adder |
| flag_ld | input | 1 | Strobe that loads the flag register |
| result | output | WIDTH | Combinational result F |
| flag_z | output | 1 | Registered zero flag |
| flag_v | output | 1 | Registered overflow flag |
| flag_c | output | 1 | Registered carry flag |
| flag_s | output | 1 | Registered sign flag |

## Verification
The bench builds two copies of the block side by side, and every check is applied to both:
- An 8-bit copy that uses the generated ripple-carry chain.
- A 4-bit copy that uses the operator-based adder.

The 8-bit copy reaches signed and unsigned boundaries such as 0x7F+1 and 0xFF+1. The 4-bit copy shares the random stimulus on its low bits, so that across a few hundred vectors most of its tiny operand space is covered, including every overflow and carry combination. Having both adder variants under the same stimulus also shows that the two agree on carry and overflow.

// File: rtl/alu_pkg.sv
package alu_pkg;

   // Arithmetic-mode steering of the adder's second input
   typedef enum logic [1:0] {
      BSEL_PASS = 2'b00,
      BSEL_INV  = 2'b01,
      BSEL_ZERO = 2'b10,
      BSEL_ONES = 2'b11
   } bsel_e;

   // Logic-mode operation codes
   typedef enum logic [1:0] {
      LOP_AND  = 2'b00,
      LOP_OR   = 2'b01,
      LOP_XOR  = 2'b10,
      LOP_NOTA = 2'b11
   } lop_e;

   typedef struct packed {
      logic z;
      logic v;
      logic c;
      logic s;
   } alu_flags_t;

endpackage

// File: rtl/alu_bsteer.sv
module alu_bsteer
   import alu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] b_in,
   input  bsel_e            sel,
   output logic [WIDTH-1:0] b_out
);
   always_comb begin
      unique case (sel)
         BSEL_PASS: b_out = b_in;
         BSEL_INV:  b_out = ~b_in;
         BSEL_ZERO: b_out = '0;
         default:   b_out = '1;
      endcase
   end
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
   parameter int WIDTH  = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  logic             ci,
   output logic [WIDTH-1:0] sum,
   output logic             co,
   output logic             ovf
);
   localparam int MSB = WIDTH - 1;

   generate
      if (RIPPLE) begin : g_ripple
         logic [WIDTH:0] cc;
         assign cc[0] = ci;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum[i]  = x[i] ^ y[i] ^ cc[i];
            assign cc[i+1] = (x[i] & y[i]) | (cc[i] & (x[i] ^ y[i]));
         end
         assign co  = cc[WIDTH];
         assign ovf = cc[WIDTH] ^ cc[MSB];
      end else begin : g_behav
         logic [WIDTH:0] wide;
         assign wide = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, ci};
         assign sum  = wide[MSB:0];
         assign co   = wide[WIDTH];
         assign ovf  = (x[MSB] == y[MSB]) && (wide[MSB] != x[MSB]);
      end
   endgenerate
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
   import alu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  lop_e             op,
   output logic [WIDTH-1:0] res
);
   always_comb begin
      unique case (op)
         LOP_AND: res = x & y;
         LOP_OR:  res = x | y;
         LOP_XOR: res = x ^ y;
         default: res = ~x;
      endcase
   end
endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg
   import alu_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       ld,
   input  alu_flags_t d,
   output alu_flags_t q
);
   always_ff @(posedge clk) begin
      if (rst)     q <= '0;
      else if (ld) q <= d;
   end

   // R11: reset clears the register
   assert_reset_clear_R11: assert property (@(posedge clk) rst |=> (q == '0));
   // R10: the strobe captures the computed flags
   assert_load_capture_R10: assert property (@(posedge clk) disable iff (rst)
      ld |=> (q == $past(d)));
   // R10: without the strobe, the flags hold
   assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
      !ld |=> $stable(q));
endmodule

// File: rtl/alu_mode_flags.sv
module alu_mode_flags
   import alu_pkg::*;
#(
   parameter int WIDTH  = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] opd_a,
   input  logic [WIDTH-1:0] opd_b,
   input  logic             mode_logic,
   input  logic [1:0]       fsel,
   input  logic             cin,
   input  logic             flag_ld,
   output logic [WIDTH-1:0] result,
   output logic             flag_z,
   output logic             flag_v,
   output logic             flag_c,
   output logic             flag_s
);
   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_width_check
         $error("alu_mode_flags: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] b_steered;
   logic [WIDTH-1:0] add_sum;
   logic [WIDTH-1:0] log_res;
   logic             add_co;
   logic             add_ovf;
   alu_flags_t       flags_next;
   alu_flags_t       flags_q;

   alu_bsteer #(.WIDTH(WIDTH)) u_bsteer (
      .b_in  (opd_b),
      .sel   (bsel_e'(fsel)),
      .b_out (b_steered)
   );

   alu_adder #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_adder (
      .x   (opd_a),
      .y   (b_steered),
      .ci  (cin),
      .sum (add_sum),
      .co  (add_co),
      .ovf (add_ovf)
   );

   alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
      .x   (opd_a),
      .y   (opd_b),
      .op  (lop_e'(fsel)),
      .res (log_res)
   );

   always_comb begin
      result       = mode_logic ? log_res : add_sum;
      flags_next.z = (result == '0);
      flags_next.s = result[MSB];
      flags_next.c = mode_logic ? 1'b0 : add_co;
      flags_next.v = mode_logic ? 1'b0 : add_ovf;
   end

   alu_status_reg u_status (
      .clk (clk),
      .rst (rst),
      .ld  (flag_ld),
      .d   (flags_next),
      .q   (flags_q)
   );

   assign flag_z = flags_q.z;
   assign flag_v = flags_q.v;
   assign flag_c = flags_q.c;
   assign flag_s = flags_q.s;

   // R4: zero steering with no carry transfers A
   assert_transfer_a_R4: assert property (@(posedge clk) disable iff (rst)
      (!mode_logic && fsel == 2'b10 && !cin) |-> (result == opd_a));
   // R1: logic select 11 yields the complement of A
   assert_not_a_R1: assert property (@(posedge clk) disable iff (rst)
      (mode_logic && fsel == 2'b11) |-> (result == ~opd_a));
   // R9: a load in logic mode leaves carry and overflow clear
   assert_logic_cv_clear_R9: assert property (@(posedge clk) disable iff (rst)
      (mode_logic && flag_ld) |=> (!flag_c && !flag_v));
   // R8: a loaded zero flag reflects an all-zero result
   assert_zero_flag_R8: assert property (@(posedge clk) disable iff (rst)
      flag_ld |=> (flag_z == ($past(result) == '0)));
endmodule

// File: tb/test_alu_mode_flags.sv
module test_alu_mode_flags;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] a = '0, b = '0;
   logic       mode = 1'b0, cin = 1'b0, ld = 1'b0;
   logic [1:0] fs = '0;
   logic [7:0] r8;
   logic [3:0] r4;
   logic       z8, v8, c8, s8, z4, v4, c4, s4;
   int         n_chk = 0, n_fail = 0;
   logic [3:0] exp8_q, exp4_q;

   always #4 clk = ~clk;

   alu_mode_flags #(.WIDTH(8), .RIPPLE(1'b1)) i_alu_mode_flags (
      .clk(clk), .rst(rst), .opd_a(a), .opd_b(b), .mode_logic(mode), .fsel(fs),
      .cin(cin), .flag_ld(ld), .result(r8),
      .flag_z(z8), .flag_v(v8), .flag_c(c8), .flag_s(s8));

   alu_mode_flags #(.WIDTH(4), .RIPPLE(1'b0)) i_alu_mode_flags_w4 (
      .clk(clk), .rst(rst), .opd_a(a[3:0]), .opd_b(b[3:0]), .mode_logic(mode), .fsel(fs),
      .cin(cin), .flag_ld(ld), .result(r4),
      .flag_z(z4), .flag_v(v4), .flag_c(c4), .flag_s(s4));

   // Reference model; flags packed {z,v,c,s}
   task automatic model(input int w, input logic [7:0] xa, input logic [7:0] xb,
                        input logic md, input logic [1:0] f, input logic ci,
                        output logic [7:0] res, output logic [3:0] fl);
      logic [8:0] mask, bb, sum;
      logic c, v;
      mask = (9'd1 << w) - 9'd1;
      c = 1'b0; v = 1'b0;
      if (md) begin
         case (f)
            2'b00: sum = {1'b0, xa & xb};
            2'b01: sum = {1'b0, xa | xb};
            2'b10: sum = {1'b0, xa ^ xb};
            default: sum = {1'b0, ~xa};
         endcase
         sum = sum & mask;
      end else begin
         case (f)
            2'b00: bb = {1'b0, xb};
            2'b01: bb = {1'b0, ~xb};
            2'b10: bb = 9'd0;
            default: bb = 9'h1FF;
         endcase
         bb = bb & mask;
         sum = ({1'b0, xa} & mask) + bb + {8'd0, ci};
         c = sum[w];
         v = (xa[w-1] == bb[w-1]) && (sum[w-1] != xa[w-1]);
         sum = sum & mask;
      end
      res = sum[7:0];
      fl = {res == 8'd0, v, c, res[w-1]};
   endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Apply one vector with load; check result then registered flags
   task automatic apply(input string req, input logic [7:0] xa, input logic [7:0] xb,
                        input logic md, input logic [1:0] f, input logic ci);
      logic [7:0] e8, e4;
      logic [3:0] f8, f4;
      @(negedge clk);
      a = xa; b = xb; mode = md; fs = f; cin = ci; ld = 1'b1;
      model(8, xa, xb, md, f, ci, e8, f8);
      model(4, xa, xb, md, f, ci, e4, f4);
      #1;
      chk({req, " result w8"}, r8, e8);
      chk({req, " result w4"}, {4'd0, r4}, e4);
      @(negedge clk);
      ld = 1'b0;
      chk({req, " R10 flags w8"}, {4'd0, z8, v8, c8, s8}, {4'd0, f8});
      chk({req, " R10 flags w4"}, {4'd0, z4, v4, c4, s4}, {4'd0, f4});
      exp8_q = f8; exp4_q = f4;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R11: flags cleared by reset
      chk("R11 reset w8", {4'd0, z8, v8, c8, s8}, 8'd0);
      chk("R11 reset w4", {4'd0, z4, v4, c4, s4}, 8'd0);
      rst = 1'b0;

      apply("R2 R7 signed ovf", 8'h7F, 8'h01, 1'b0, 2'b00, 1'b0);
      apply("R2 R7 carry wrap", 8'hFF, 8'h01, 1'b0, 2'b00, 1'b0);
      apply("R2 add w carry", 8'h10, 8'h20, 1'b0, 2'b00, 1'b1);
      apply("R3 sub equal", 8'h55, 8'h55, 1'b0, 2'b01, 1'b1);
      apply("R3 ones comp", 8'h30, 8'h10, 1'b0, 2'b01, 1'b0);
      apply("R3 R7 sub ovf", 8'h80, 8'h01, 1'b0, 2'b01, 1'b1);
      apply("R4 transfer", 8'hA5, 8'h3C, 1'b0, 2'b10, 1'b0);
      apply("R4 increment", 8'hFF, 8'h00, 1'b0, 2'b10, 1'b1);
      apply("R5 decrement zero", 8'h00, 8'h12, 1'b0, 2'b11, 1'b0);
      apply("R5 transfer", 8'h80, 8'h12, 1'b0, 2'b11, 1'b1);
      for (int op = 0; op < 4; op++) begin
         apply("R1 R6 R9 logic cin0", 8'hC3, 8'hA5, 1'b1, op[1:0], 1'b0);
         apply("R1 R6 R9 logic cin1", 8'hC3, 8'hA5, 1'b1, op[1:0], 1'b1);
      end
      apply("R8 logic zero", 8'hF0, 8'h0F, 1'b1, 2'b00, 1'b1);

      // R10: without the strobe the flags hold despite new operands
      @(negedge clk);
      a = 8'h00; b = 8'h00; mode = 1'b0; fs = 2'b00; cin = 1'b0; ld = 1'b0;
      @(negedge clk);
      chk("R10 hold w8", {4'd0, z8, v8, c8, s8}, {4'd0, exp8_q});
      chk("R10 hold w4", {4'd0, z4, v4, c4, s4}, {4'd0, exp4_q});

      for (int i = 0; i < 400; i++) begin
         logic [31:0] rv;
         rv = $urandom;
         apply("R2 R3 R4 R5 R1 R7 R8 random", rv[7:0], rv[15:8], rv[16], rv[18:17], rv[19]);
      end

      // R11: reset clears after activity
      apply("R8 sign", 8'h80, 8'h00, 1'b0, 2'b10, 1'b0);
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      chk("R11 reset again w8", {4'd0, z8, v8, c8, s8}, 8'd0);
      chk("R11 reset again w4", {4'd0, z4, v4, c4, s4}, 8'd0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #1000000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule